// File: doc/BRIEF.md
# Line Frame Builder and Aligner with Alternating Sync

This block sits between parallel channel registers and a serial line-bit stream running at 80 or 160 kbit/s with 8 kHz frames. On the send side it captures the two bearer bytes, one or two signalling bits and a housekeeping bit at the start of every frame. It places a single marker bit that flips value every frame in front of them and shifts the frame out, one bit per line-bit strobe. The payload bits may optionally be whitened by a short LFSR that restarts at each marker bit.

On the receive side the block hunts through the incoming bit stream for the one bit position whose value alternates frame after frame. It declares alignment after a run of good frames and drops it after a run of violations. Once aligned, it removes the whitening and hands the recovered channel fields to the parallel side with a one-cycle strobe. The two ends of a link take opposite roles. Each role whitens with its own polynomial, so a receiver always uses the polynomial of the role opposite to its own. Line coding, filtering and echo handling lie outside this block.

Top module: `lfr_line_framer`

## Requirements
- R1: With `wide_mode`=0 a frame is 10 line bits, sent in this order: marker, D0, then B1 bit 7 down to bit 0.
- R2: With `wide_mode`=1 a frame is 20 line bits, sent in this order: marker, HK, D0, D1, B1 bit 7 down to 0, then B2 bit 7 down to 0.
- R3: The transmitted marker is 1 in the first frame after reset and inverts in every later frame. It is never whitened.
- R4: With `scr_en`=1, every transmitted payload bit is XORed with a key bit. A 7-bit state is loaded with 7'h7F on each marker bit. For each payload bit the key is state bit 6, and the state then becomes {state[5:0], XOR of the state bits selected by the tap mask}. The master (`role_master`=1) uses mask 7'b1100000 and the slave uses mask 7'b1001000.
- R5: The receiver removes whitening with the same rule but with the tap mask of the opposite role, and it recovers the sent channel fields exactly.
- R6: Starting from a candidate position, `locked` rises on the line bit that completes 8 consecutive correct alternations of the marker, which is the 9th marker bit seen at that position.
- R7: While not locked, a marker candidate that fails to alternate moves the candidate position one line bit later. A stream that starts at an arbitrary bit offset is therefore eventually acquired and decoded.
- R8: While locked, 3 consecutive non-alternating markers clear `locked` on the third one. Fewer violations followed by a correct marker leave `locked` set.
- R9: While `locked` is low, `rx_valid` stays low and the receive field outputs keep their values.
- R10: In a locked frame, the receive fields update and `rx_valid` pulses for one cycle right after the last bit of the frame is taken.
- R11: Nothing advances without `bit_en`. `tx_frame_start` is high exactly when the next strobe sends a marker bit, and the transmit fields are captured on that strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_en | input | 1 | One line-bit strobe |
| wide_mode | input | 1 | 1 selects 20-bit frames (160 kbit/s), 0 selects 10-bit frames |
| role_master | input | 1 | 1 for the master role, 0 for the slave role |
| scr_en | input | 1 | Enables payload whitening on both directions |
| tx_b1 | input | 8 | First bearer byte to send |
| tx_b2 | input | 8 | Second bearer byte to send (wide only) |
| tx_d0 | input | 1 | Signalling bit 0 to send |
| tx_d1 | input | 1 | Signalling bit 1 to send (wide only) |
| tx_hk | input | 1 | Housekeeping bit to send (wide only) |
| tx_frame_start | output | 1 | Next strobe starts a frame and captures the transmit fields |
| line_tx | output | 1 | Serial line bit out |
| line_rx | input | 1 | Serial line bit in |
| rx_b1 | output | 8 | Recovered first bearer byte |
| rx_b2 | output | 8 | Recovered second bearer byte |
| rx_d0 | output | 1 | Recovered signalling bit 0 |
| rx_d1 | output | 1 | Recovered signalling bit 1 |
| rx_hk | output | 1 | Recovered housekeeping bit |
| rx_valid | output | 1 | One-cycle strobe when the fields update |
| locked | output | 1 | Frame alignment held |

## Verification
The hardest states to reach are the ones inside the receive alignment machine: a hunt from a misaligned start, and a loss of lock that must fire on exactly the third bad marker. The bench reaches both by generating the far-end line stream itself. For the hunt it prepends a few filler bits to a clean frame stream. For the loss of lock it inverts chosen marker bits, first in a run broken by a good frame, then in an unbroken run of three. Holding the payload constant keeps every non-marker position from alternating, so the acquisition is deterministic and no false alignment can occur.

// File: rtl/lfr_pkg.sv
package lfr_pkg;

   localparam int CHAN_W = 8;
   localparam int PAY_W  = 3 + 2 * CHAN_W;

   typedef struct packed {
      logic [CHAN_W-1:0] b1;
      logic [CHAN_W-1:0] b2;
      logic              d0;
      logic              d1;
      logic              hk;
   } chan_t;

   // Payload is left-justified; the first bit on the line is the MSB.
   function automatic logic [PAY_W-1:0] pack_payload(input chan_t c, input logic wide);
      logic [PAY_W-1:0] w;
      if (wide) w = {c.hk, c.d0, c.d1, c.b1, c.b2};
      else      w = {c.d0, c.b1, {(PAY_W-1-CHAN_W){1'b0}}};
      return w;
   endfunction

   // Receive word is right-justified: the last bit taken sits in bit 0.
   function automatic chan_t unpack_payload(input logic [PAY_W-1:0] w, input logic wide);
      chan_t c;
      if (wide) begin
         c.hk = w[PAY_W-1];
         c.d0 = w[PAY_W-2];
         c.d1 = w[PAY_W-3];
         c.b1 = w[2*CHAN_W-1:CHAN_W];
         c.b2 = w[CHAN_W-1:0];
      end else begin
         c.hk = 1'b0;
         c.d1 = 1'b0;
         c.d0 = w[CHAN_W];
         c.b1 = w[CHAN_W-1:0];
         c.b2 = '0;
      end
      return c;
   endfunction

endpackage

// File: rtl/lfr_scrambler.sv
module lfr_scrambler #(
   parameter int           W    = 7,
   parameter logic [W-1:0] SEED = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         restart,
   input  logic         step,
   input  logic [W-1:0] taps,
   output logic         key
);

   logic [W-1:0] st_q;

   generate
      if (W < 3) begin : g_bad_width
         $error("lfr_scrambler: W must be at least 3");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       st_q <= SEED;
      else if (restart) st_q <= SEED;
      else if (step)    st_q <= {st_q[W-2:0], ^(st_q & taps)};
   end

   assign key = st_q[W-1];

endmodule

// File: rtl/lfr_tx.sv
module lfr_tx
   import lfr_pkg::*;
#(
   parameter int           SCR_W = 7,
   parameter logic [SCR_W-1:0] SCR_SEED = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_en,
   input  logic             wide,
   input  logic             scr_en,
   input  logic [SCR_W-1:0] taps,
   input  chan_t            fields,
   output logic             frame_start,
   output logic             line_bit
);

   localparam int LEN_NB = 2 + CHAN_W;
   localparam int LEN_WB = 4 + 2 * CHAN_W;
   localparam int POS_W  = $clog2(LEN_WB);
   localparam logic [POS_W-1:0] LAST_NB = POS_W'(LEN_NB - 1);
   localparam logic [POS_W-1:0] LAST_WB = POS_W'(LEN_WB - 1);

   logic [POS_W-1:0] pos_q;
   logic [PAY_W-1:0] sh_q;
   logic             mark_q;
   logic             key;
   logic [POS_W-1:0] last;

   assign last        = wide ? LAST_WB : LAST_NB;
   assign frame_start = (pos_q == '0);

   lfr_scrambler #(.W(SCR_W), .SEED(SCR_SEED)) u_scr (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (bit_en && frame_start),
      .step    (bit_en && !frame_start),
      .taps    (taps),
      .key     (key)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q    <= '0;
         sh_q     <= '0;
         mark_q   <= 1'b1;
         line_bit <= 1'b0;
      end else if (bit_en) begin
         if (frame_start) begin
            line_bit <= mark_q;
            mark_q   <= ~mark_q;
            sh_q     <= pack_payload(fields, wide);
            pos_q    <= POS_W'(1);
         end else begin
            line_bit <= sh_q[PAY_W-1] ^ (scr_en & key);
            sh_q     <= {sh_q[PAY_W-2:0], 1'b0};
            pos_q    <= (pos_q == last) ? '0 : pos_q + POS_W'(1);
         end
      end
   end

endmodule

// File: rtl/lfr_rx.sv
module lfr_rx
   import lfr_pkg::*;
#(
   parameter int               SCR_W       = 7,
   parameter logic [SCR_W-1:0] SCR_SEED    = '1,
   parameter int               LOCK_FRAMES = 8,
   parameter int               DROP_FRAMES = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_en,
   input  logic             wide,
   input  logic             scr_en,
   input  logic [SCR_W-1:0] taps,
   input  logic             line_bit,
   output chan_t            fields,
   output logic             valid,
   output logic             locked,
   output logic [$clog2(4 + 2 * lfr_pkg::CHAN_W)-1:0] pos
);

   localparam int LEN_NB = 2 + CHAN_W;
   localparam int LEN_WB = 4 + 2 * CHAN_W;
   localparam int POS_W  = $clog2(LEN_WB);
   localparam int GW     = $clog2(LOCK_FRAMES + 1);
   localparam int BW     = $clog2(DROP_FRAMES + 1);
   localparam logic [POS_W-1:0] LAST_NB = POS_W'(LEN_NB - 1);
   localparam logic [POS_W-1:0] LAST_WB = POS_W'(LEN_WB - 1);

   logic [POS_W-1:0] pos_q;
   logic [PAY_W-1:0] sh_q;
   logic             have_prev_q;
   logic             prev_q;
   logic [GW-1:0]    good_q;
   logic [BW-1:0]    bad_q;
   logic             key;
   logic             dbit;
   logic             at_mark;
   logic [POS_W-1:0] last;

   assign last    = wide ? LAST_WB : LAST_NB;
   assign at_mark = (pos_q == '0);
   assign dbit    = line_bit ^ (scr_en & key);
   assign pos     = pos_q;

   lfr_scrambler #(.W(SCR_W), .SEED(SCR_SEED)) u_dscr (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (bit_en && at_mark),
      .step    (bit_en && !at_mark),
      .taps    (taps),
      .key     (key)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q       <= '0;
         sh_q        <= '0;
         have_prev_q <= 1'b0;
         prev_q      <= 1'b0;
         good_q      <= '0;
         bad_q       <= '0;
         locked      <= 1'b0;
         fields      <= '0;
         valid       <= 1'b0;
      end else begin
         valid <= 1'b0;
         if (bit_en) begin
            if (at_mark) begin
               if (!have_prev_q) begin
                  // first look at this candidate: remember it only
                  prev_q      <= line_bit;
                  have_prev_q <= 1'b1;
                  pos_q       <= POS_W'(1);
               end else if (line_bit != prev_q) begin
                  prev_q <= line_bit;
                  pos_q  <= POS_W'(1);
                  if (locked) begin
                     bad_q <= '0;
                  end else if (good_q == GW'(LOCK_FRAMES - 1)) begin
                     locked <= 1'b1;
                     good_q <= '0;
                  end else begin
                     good_q <= good_q + GW'(1);
                  end
               end else if (locked) begin
                  if (bad_q == BW'(DROP_FRAMES - 1)) begin
                     locked      <= 1'b0;
                     bad_q       <= '0;
                     good_q      <= '0;
                     have_prev_q <= 1'b0;
                     pos_q       <= '0;
                  end else begin
                     bad_q  <= bad_q + BW'(1);
                     prev_q <= ~prev_q;
                     pos_q  <= POS_W'(1);
                  end
               end else begin
                  // slip: the next line bit becomes the candidate
                  have_prev_q <= 1'b0;
                  good_q      <= '0;
                  pos_q       <= '0;
               end
            end else begin
               sh_q <= {sh_q[PAY_W-2:0], dbit};
               if (pos_q == last) begin
                  pos_q <= '0;
                  if (locked) begin
                     fields <= unpack_payload({sh_q[PAY_W-2:0], dbit}, wide);
                     valid  <= 1'b1;
                  end
               end else begin
                  pos_q <= pos_q + POS_W'(1);
               end
            end
         end
      end
   end

endmodule

// File: rtl/lfr_line_framer.sv
module lfr_line_framer
   import lfr_pkg::*;
#(
   parameter int               SCR_W       = 7,
   parameter logic [SCR_W-1:0] SCR_SEED    = 7'h7F,
   parameter logic [SCR_W-1:0] TAPS_MST    = 7'b1100000,
   parameter logic [SCR_W-1:0] TAPS_SLV    = 7'b1001000,
   parameter int               LOCK_FRAMES = 8,
   parameter int               DROP_FRAMES = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bit_en,
   input  logic       wide_mode,
   input  logic       role_master,
   input  logic       scr_en,
   input  logic [7:0] tx_b1,
   input  logic [7:0] tx_b2,
   input  logic       tx_d0,
   input  logic       tx_d1,
   input  logic       tx_hk,
   output logic       tx_frame_start,
   output logic       line_tx,
   input  logic       line_rx,
   output logic [7:0] rx_b1,
   output logic [7:0] rx_b2,
   output logic       rx_d0,
   output logic       rx_d1,
   output logic       rx_hk,
   output logic       rx_valid,
   output logic       locked
);

   localparam int POS_W = $clog2(4 + 2 * CHAN_W);

   generate
      if (LOCK_FRAMES < 2) begin : g_bad_lock
         $error("lfr_line_framer: LOCK_FRAMES must be at least 2");
      end
      if (DROP_FRAMES < 1) begin : g_bad_drop
         $error("lfr_line_framer: DROP_FRAMES must be at least 1");
      end
      if (SCR_SEED == '0) begin : g_bad_seed
         $error("lfr_line_framer: SCR_SEED must be nonzero");
      end
      if (TAPS_MST == TAPS_SLV) begin : g_bad_taps
         $error("lfr_line_framer: roles need distinct tap masks");
      end
      if (CHAN_W != 8) begin : g_bad_chan
         $error("lfr_line_framer: port widths assume 8-bit channels");
      end
   endgenerate

   chan_t            tx_fields;
   chan_t            rx_fields;
   logic [SCR_W-1:0] tx_taps;
   logic [SCR_W-1:0] rx_taps;
   logic [POS_W-1:0] rx_pos;

   assign tx_fields = '{b1: tx_b1, b2: tx_b2, d0: tx_d0, d1: tx_d1, hk: tx_hk};
   assign tx_taps   = role_master ? TAPS_MST : TAPS_SLV;
   assign rx_taps   = role_master ? TAPS_SLV : TAPS_MST;

   lfr_tx #(.SCR_W(SCR_W), .SCR_SEED(SCR_SEED)) u_tx (
      .clk         (clk),
      .rst_n       (rst_n),
      .bit_en      (bit_en),
      .wide        (wide_mode),
      .scr_en      (scr_en),
      .taps        (tx_taps),
      .fields      (tx_fields),
      .frame_start (tx_frame_start),
      .line_bit    (line_tx)
   );

   lfr_rx #(
      .SCR_W       (SCR_W),
      .SCR_SEED    (SCR_SEED),
      .LOCK_FRAMES (LOCK_FRAMES),
      .DROP_FRAMES (DROP_FRAMES)
   ) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .bit_en   (bit_en),
      .wide     (wide_mode),
      .scr_en   (scr_en),
      .taps     (rx_taps),
      .line_bit (line_rx),
      .fields   (rx_fields),
      .valid    (rx_valid),
      .locked   (locked),
      .pos      (rx_pos)
   );

   assign rx_b1 = rx_fields.b1;
   assign rx_b2 = rx_fields.b2;
   assign rx_d0 = rx_fields.d0;
   assign rx_d1 = rx_fields.d1;
   assign rx_hk = rx_fields.hk;

endmodule

// File: rtl/lfr_line_framer_sva.sv
module lfr_line_framer_sva #(
   parameter int POS_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bit_en,
   input logic             line_tx,
   input logic             tx_frame_start,
   input logic             rx_valid,
   input logic             locked,
   input logic [7:0]       rx_b1,
   input logic [7:0]       rx_b2,
   input logic             rx_d0,
   input logic             rx_d1,
   input logic             rx_hk,
   input logic [POS_W-1:0] rx_pos
);

   AST_VALID_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> locked); // R9

   AST_HOLD_WHILE_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      !locked |=> $stable({rx_b1, rx_b2, rx_d0, rx_d1, rx_hk})); // R9

   AST_VALID_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid); // R10

   AST_TX_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_en |=> ($stable(line_tx) && $stable(tx_frame_start))); // R11

   AST_LOCK_ON_MARKER: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked) |-> (rx_pos == POS_W'(1))); // R6

   AST_LOCK_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(locked) || $fell(locked)) |-> $past(bit_en)); // R8

endmodule

bind lfr_line_framer lfr_line_framer_sva #(.POS_W(POS_W)) u_sva (
   .clk            (clk),
   .rst_n          (rst_n),
   .bit_en         (bit_en),
   .line_tx        (line_tx),
   .tx_frame_start (tx_frame_start),
   .rx_valid       (rx_valid),
   .locked         (locked),
   .rx_b1          (rx_b1),
   .rx_b2          (rx_b2),
   .rx_d0          (rx_d0),
   .rx_d1          (rx_d1),
   .rx_hk          (rx_hk),
   .rx_pos         (rx_pos)
);

// File: tb/lfr_line_framer_tb_top.sv
module lfr_line_framer_tb_top;
   import lfr_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam logic [6:0] M_MST = 7'b1100000;
   localparam logic [6:0] M_SLV = 7'b1001000;

   logic clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic rst_n = 1'b0, bit_en = 1'b0, wide_mode = 1'b0, role_master = 1'b1, scr_en = 1'b0;
   logic line_rx = 1'b0;
   chan_t tx_drv = '0;
   logic tx_frame_start, line_tx, rx_valid, locked;
   logic [7:0] rx_b1, rx_b2;
   logic rx_d0, rx_d1, rx_hk;

   lfr_line_framer dut_i (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .wide_mode(wide_mode),
      .role_master(role_master), .scr_en(scr_en),
      .tx_b1(tx_drv.b1), .tx_b2(tx_drv.b2), .tx_d0(tx_drv.d0), .tx_d1(tx_drv.d1),
      .tx_hk(tx_drv.hk), .tx_frame_start(tx_frame_start), .line_tx(line_tx),
      .line_rx(line_rx), .rx_b1(rx_b1), .rx_b2(rx_b2), .rx_d0(rx_d0), .rx_d1(rx_d1),
      .rx_hk(rx_hk), .rx_valid(rx_valid), .locked(locked)
   );

   int n_cmp = 0, n_bad = 0;
   int gap = 0;
   bit tx_chk = 1'b0;
   // bench transmit model
   int t_pos; logic t_mark; logic [6:0] t_key; chan_t t_snap;
   // bench far-end generator
   logic r_mark; logic [6:0] r_key;
   // per-tick / per-frame observations
   logic last_valid, last_locked, f_lock, f_valid;
   int spur;

   localparam chan_t F1 = '{b1: 8'hA5, b2: 8'h00, d0: 1'b1, d1: 1'b0, hk: 1'b0};
   localparam chan_t F2 = '{b1: 8'h3C, b2: 8'hE1, d0: 1'b0, d1: 1'b1, hk: 1'b1};
   localparam chan_t F3 = '{b1: 8'h96, b2: 8'h5A, d0: 1'b1, d1: 1'b0, hk: 1'b1};
   localparam chan_t F4 = '{b1: 8'h0F, b2: 8'hC3, d0: 1'b0, d1: 1'b1, hk: 1'b0};

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int flen();
      return wide_mode ? 20 : 10;
   endfunction

   function automatic logic [6:0] adv(input logic [6:0] s, input logic [6:0] m);
      return {s[5:0], ^(s & m)};
   endfunction

   // bit j (1-based after the marker) of a frame, from the R1/R2 order
   function automatic logic pay_bit(input chan_t f, input logic wide, input int j);
      if (!wide) begin
         if (j == 1) return f.d0;
         return f.b1[9 - j];
      end
      case (j)
         1: return f.hk;
         2: return f.d0;
         3: return f.d1;
         default: return (j <= 11) ? f.b1[11 - j] : f.b2[19 - j];
      endcase
   endfunction

   function automatic logic [31:0] rx_now();
      return {5'b0, rx_hk, rx_d1, rx_d0, rx_b2, rx_b1, 8'b0};
   endfunction

   function automatic logic [31:0] as_word(input chan_t f);
      return {5'b0, f.hk, f.d1, f.d0, f.b2, f.b1, 8'b0};
   endfunction

   task automatic do_reset(input logic wide, input logic master, input logic scr);
      bit_en = 1'b0; rst_n = 1'b0;
      wide_mode = wide; role_master = master; scr_en = scr;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_pos = 0; t_mark = 1'b1; t_key = 7'h7F;
      r_mark = 1'b1; r_key = 7'h7F;
      @(negedge clk);
   endtask

   task automatic tick(input logic b);
      logic exp;
      logic [6:0] m;
      string tag;
      m = role_master ? M_MST : M_SLV;
      if (t_pos == 0) begin
         if (tx_chk) chk(tx_frame_start == 1'b1, "R11 frame start before marker", tx_frame_start, 1);
         t_snap = tx_drv;
      end
      line_rx = b; bit_en = 1'b1;
      @(negedge clk);
      bit_en = 1'b0;
      last_valid = rx_valid; last_locked = locked;
      if (t_pos == 0) begin
         exp = t_mark; t_mark = ~t_mark; t_key = 7'h7F; tag = "R3 marker";
      end else begin
         exp = pay_bit(t_snap, wide_mode, t_pos) ^ (scr_en & t_key[6]);
         t_key = adv(t_key, m);
         tag = scr_en ? "R4 whitened bit" : (wide_mode ? "R2 wide bit" : "R1 narrow bit");
      end
      if (tx_chk) chk(line_tx == exp, tag, line_tx, exp);
      t_pos = (t_pos == flen() - 1) ? 0 : t_pos + 1;
      if (gap > 0) begin
         logic held;
         held = line_tx;
         repeat (gap) @(negedge clk);
         chk(line_tx == held && rx_valid == 1'b0, "R11 no change without strobe", line_tx, held);
      end
   endtask

   task automatic rx_frame(input chan_t f, input bit flip);
      logic b;
      logic [6:0] fm;
      fm = role_master ? M_SLV : M_MST;
      for (int j = 0; j < flen(); j++) begin
         if (j == 0) begin
            b = r_mark ^ flip; r_mark = ~r_mark; r_key = 7'h7F;
         end else begin
            b = pay_bit(f, wide_mode, j) ^ (scr_en & r_key[6]);
            r_key = adv(r_key, fm);
         end
         tick(b);
         if (j == 0) f_lock = last_locked;
         if (j < flen() - 1 && last_valid) spur++;
         if (j == flen() - 1) f_valid = last_valid;
      end
   endtask

   task automatic t_reset_state();
      do_reset(1'b0, 1'b1, 1'b0);
      chk(locked == 1'b0, "R6 unlocked after reset", locked, 0);
      chk(rx_valid == 1'b0, "R10 no strobe after reset", rx_valid, 0);
      chk(tx_frame_start == 1'b1, "R11 frame start after reset", tx_frame_start, 1);
   endtask

   task automatic t_narrow_lock();
      do_reset(1'b0, 1'b1, 1'b0);
      tx_drv = F2; tx_chk = 1'b1; spur = 0;
      for (int n = 0; n < 10; n++) begin
         rx_frame(F1, 1'b0);
         chk(f_lock == (n >= 8), "R6 lock on ninth marker", f_lock, n >= 8);
         if (n == 8) begin
            chk(f_valid == 1'b1, "R10 strobe after last bit", f_valid, 1);
            chk({rx_b1, rx_d0} == {F1.b1, F1.d0}, "R1 narrow fields recovered",
                {rx_b1, rx_d0}, {F1.b1, F1.d0});
         end
      end
      chk(spur == 0, "R10 strobe only at frame end", spur, 0);
      tx_chk = 1'b0;
   endtask

   task automatic t_wide_scrambled();
      for (int r = 0; r < 2; r++) begin
         do_reset(1'b1, r[0], 1'b1);
         tx_drv = F2; tx_chk = 1'b1;
         for (int n = 0; n < 11; n++) rx_frame(F3, 1'b0);
         chk(locked == 1'b1, "R5 locked with whitening", locked, 1);
         chk(f_valid == 1'b1, "R5 strobe with whitening", f_valid, 1);
         chk(rx_now() == as_word(F3), "R5 descrambled fields", rx_now(), as_word(F3));
         tx_drv = F4;
         for (int n = 0; n < 2; n++) rx_frame(F4, 1'b0);
         chk(rx_now() == as_word(F4), "R2 wide fields updated", rx_now(), as_word(F4));
         tx_chk = 1'b0;
      end
   endtask

   task automatic t_hunt();
      do_reset(1'b0, 1'b1, 1'b0);
      tx_drv = F1; tx_chk = 1'b1;
      tick(1'b0); tick(1'b0); tick(1'b1);
      for (int k = 0; k < 80 && !locked; k++) rx_frame(F4, 1'b0);
      chk(locked == 1'b1, "R7 acquired from offset", locked, 1);
      rx_frame(F4, 1'b0);
      chk(f_valid == 1'b1, "R7 strobe after acquisition", f_valid, 1);
      chk({rx_b1, rx_d0} == {F4.b1, F4.d0}, "R7 fields after acquisition",
          {rx_b1, rx_d0}, {F4.b1, F4.d0});
      tx_chk = 1'b0;
   endtask

   task automatic t_drop();
      logic [31:0] held;
      do_reset(1'b0, 1'b0, 1'b0);
      for (int n = 0; n < 9; n++) rx_frame(F1, 1'b0);
      rx_frame(F1, 1'b1);
      chk(f_lock == 1'b1, "R8 kept after one violation", f_lock, 1);
      rx_frame(F1, 1'b1);
      chk(f_lock == 1'b1, "R8 kept after two violations", f_lock, 1);
      rx_frame(F1, 1'b0);
      chk(f_lock == 1'b1, "R8 good marker clears count", f_lock, 1);
      rx_frame(F1, 1'b1);
      rx_frame(F1, 1'b1);
      chk(f_lock == 1'b1, "R8 still locked at second of run", f_lock, 1);
      rx_frame(F1, 1'b1);
      chk(f_lock == 1'b0, "R8 dropped on third violation", f_lock, 0);
      held = rx_now(); spur = 0;
      for (int n = 0; n < 4; n++) begin
         rx_frame(F4, 1'b0);
         if (f_valid) spur++;
      end
      chk(spur == 0, "R9 no strobe while unlocked", spur, 0);
      chk(rx_now() == held, "R9 outputs held while unlocked", rx_now(), held);
   endtask

   task automatic t_gaps();
      do_reset(1'b1, 1'b0, 1'b0);
      gap = 2; tx_drv = F3; tx_chk = 1'b1;
      for (int n = 0; n < 10; n++) rx_frame(F2, 1'b0);
      chk(locked == 1'b1, "R11 lock with strobe gaps", locked, 1);
      chk(rx_now() == as_word(F2), "R11 fields with strobe gaps", rx_now(), as_word(F2));
      gap = 0; tx_chk = 1'b0;
   endtask

   initial begin
      t_reset_state();
      t_narrow_lock();
      t_wide_scrambled();
      t_hunt();
      t_drop();
      t_gaps();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule